// File: doc/BRIEF.md
# Multi-Pulse Circular Frame Buffer Controller

This block keeps the most recent N pulse echoes in an external memory and, once the buffer is full, presents the matching frame of every stored pulse in parallel. N is chosen at run time, from one up to a fixed maximum of regions, and the per-region depth in frames is also chosen at run time. The external address space is cut into equal regions, one per possible pulse. Each region is a sequence of fixed-stride frame slots.

Incoming frames arrive as a stream of wide words, and each beat is passed straight out as a memory write request. The block runs in two phases. While filling, it writes frames slot after slot, moving on to the next region when the configured depth is reached, until every active region has been written once. After that it writes each new frame over the oldest stored frame. It then reads the same frame slot back from every active region. The read words come back tagged with their region and are pushed into one output FIFO per region.

A reservation count per FIFO covers both the words already held and the reads still in flight. Reads for a frame start only when every active FIFO can take a whole frame. Input is refused while reads are pending.

Top module: `frame_ring_ctrl`

## Requirements
- R1: A memory request for region r, frame slot f and word w carries byte address r*REGION_FRAMES*FRAME_BYTES + f*FRAME_BYTES + w*(WORD_W/8).
- R2: After reset or restart, frames are written slot 0, 1, … up to depth-1 of region 0, then the same for region 1, and so on through region N-1. No read request is issued during this fill phase.
- R3: In steady state the write position keeps advancing one slot per frame. After the last slot of a region it moves to slot 0 of the next region, and after region N-1 it moves back to region 0.
- R4: Each steady-state frame write is followed by reads of that frame's slot. Regions go in ascending order 0..N-1, and words go in ascending order within each region. Input is refused until the last read is accepted.
- R5: A returned word tagged with region r is pushed into output FIFO r in arrival order. A FIFO whose region is inactive receives nothing.
- R6: Reads for a frame start only when every active FIFO's count of held plus in-flight words is at most FIFO_DEPTH-WORDS_PER_FRAME. While reads wait, input is refused.
- R7: Any change of the effective pulse count or depth discards the current position and restarts the fill phase at region 0, slot 0, word 0.
- R8: A pulse count of 0 acts as 1, and a count above MAX_REGIONS acts as MAX_REGIONS. A depth of 0 acts as 1, and a depth above REGION_FRAMES acts as REGION_FRAMES.
- R9: While reset is held and just after it, no write, read or FIFO output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pulses | input | $clog2(MAX_REGIONS+1) | Requested number of active pulse regions |
| cfg_depth | input | $clog2(REGION_FRAMES+1) | Requested frames per region |
| in_valid | input | 1 | Input word valid |
| in_data | input | WORD_W | Input frame word |
| in_ready | output | 1 | Input word accepted when valid |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | WORD_W | Write data |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | ADDR_W | Read byte address |
| rd_tag | output | $clog2(MAX_REGIONS) | Region the read belongs to |
| rsp_valid | input | 1 | Read data returning |
| rsp_tag | input | $clog2(MAX_REGIONS) | Region tag of returning data |
| rsp_data | input | WORD_W | Returning read data |
| out_valid | output | MAX_REGIONS | Per-region FIFO holds a word |
| out_data | output | MAX_REGIONS*WORD_W | Per-region FIFO head words, region r at bits r*WORD_W upward |
| out_pop | input | MAX_REGIONS | Per-region FIFO pop |

## Verification
A wrong write pointer shows up on the first address of the next frame: the write lands in the wrong region or slot, and the data popped from a FIFO one read burst later carries the wrong frame tag. A lost or false phase change shows within one frame, as reads appearing during fill or missing after it. A reservation count that leaks either stalls input for good once the FIFOs drain, or lets a read start while a FIFO is still full, and the overflow assertion fires when that word returns. Restart and clamping errors show on the very next frame address.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef enum logic [1:0] {
    ST_FILL     = 2'd0,
    ST_STEADY   = 2'd1,
    ST_RD_WAIT  = 2'd2,
    ST_RD_ISSUE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/fbuf_addr.sv
module fbuf_addr #(
  parameter int ADDR_W       = 32,
  parameter int RIDX_W       = 6,
  parameter int FRM_W        = 15,
  parameter int WRD_W        = 7,
  parameter int REGION_BYTES = 2048,
  parameter int FRAME_BYTES  = 2048,
  parameter int WORD_BYTES   = 24
) (
  input  logic [RIDX_W-1:0] region,
  input  logic [FRM_W-1:0]  frame,
  input  logic [WRD_W-1:0]  word,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    addr = ADDR_W'(region) * ADDR_W'(REGION_BYTES)
         + ADDR_W'(frame)  * ADDR_W'(FRAME_BYTES)
         + ADDR_W'(word)   * ADDR_W'(WORD_BYTES);
  end
endmodule

// File: rtl/fbuf_seq.sv
module fbuf_seq
  import fbuf_pkg::*;
#(
  parameter int MAX_REGIONS     = 40,
  parameter int REGION_FRAMES   = 18823,
  parameter int WORDS_PER_FRAME = 85,
  localparam int RIDX_W = $clog2(MAX_REGIONS),
  localparam int CNT_W  = $clog2(MAX_REGIONS + 1),
  localparam int FRM_W  = $clog2(REGION_FRAMES),
  localparam int DEP_W  = $clog2(REGION_FRAMES + 1),
  localparam int WRD_W  = $clog2(WORDS_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  n_act,
  input  logic [DEP_W-1:0]  depth,
  input  logic              restart,
  input  logic              in_valid,
  input  logic              wr_ready,
  input  logic              rd_ready,
  input  logic              room_ok,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [RIDX_W-1:0] wr_region,
  output logic [FRM_W-1:0]  cur_frame,
  output logic [WRD_W-1:0]  wr_word,
  output logic              rd_valid,
  output logic [RIDX_W-1:0] rd_region,
  output logic [WRD_W-1:0]  rd_word
);
  seq_state_t        st_q, st_d;
  logic [RIDX_W-1:0] reg_q, reg_d, rreg_q, rreg_d;
  logic [FRM_W-1:0]  frm_q, frm_d;
  logic [WRD_W-1:0]  wrd_q, wrd_d, rwrd_q, rwrd_d;
  logic writing, beat, wlast, rbeat, rwlast, last_reg, last_frm, last_rreg;

  always_comb begin
    writing   = (st_q == ST_FILL || st_q == ST_STEADY) && !restart;
    in_ready  = writing && wr_ready;
    wr_valid  = writing && in_valid;
    beat      = wr_valid && wr_ready;
    wlast     = (wrd_q == WRD_W'(WORDS_PER_FRAME - 1));
    rd_valid  = (st_q == ST_RD_ISSUE) && !restart;
    rbeat     = rd_valid && rd_ready;
    rwlast    = (rwrd_q == WRD_W'(WORDS_PER_FRAME - 1));
    last_reg  = (CNT_W'(reg_q) == n_act - CNT_W'(1));
    last_rreg = (CNT_W'(rreg_q) == n_act - CNT_W'(1));
    last_frm  = (DEP_W'(frm_q) == depth - DEP_W'(1));
  end

  always_comb begin
    st_d   = st_q;
    reg_d  = reg_q;
    frm_d  = frm_q;
    wrd_d  = wrd_q;
    rreg_d = rreg_q;
    rwrd_d = rwrd_q;
    if (restart) begin
      st_d   = ST_FILL;
      reg_d  = '0;
      frm_d  = '0;
      wrd_d  = '0;
      rreg_d = '0;
      rwrd_d = '0;
    end else begin
      unique case (st_q)
        ST_FILL, ST_STEADY: begin
          if (beat) begin
            wrd_d = wlast ? '0 : wrd_q + WRD_W'(1);
            if (wlast) begin
              if (st_q == ST_STEADY) begin
                st_d = ST_RD_WAIT;
              end else if (last_frm) begin
                frm_d = '0;
                if (last_reg) begin
                  reg_d = '0;
                  st_d  = ST_STEADY;
                end else begin
                  reg_d = reg_q + RIDX_W'(1);
                end
              end else begin
                frm_d = frm_q + FRM_W'(1);
              end
            end
          end
        end
        ST_RD_WAIT: begin
          if (room_ok) begin
            st_d   = ST_RD_ISSUE;
            rreg_d = '0;
            rwrd_d = '0;
          end
        end
        ST_RD_ISSUE: begin
          if (rbeat) begin
            rwrd_d = rwlast ? '0 : rwrd_q + WRD_W'(1);
            if (rwlast) rreg_d = rreg_q + RIDX_W'(1);
            if (rwlast && last_rreg) begin
              st_d = ST_STEADY;
              if (last_frm) begin
                frm_d = '0;
                reg_d = last_reg ? '0 : reg_q + RIDX_W'(1);
              end else begin
                frm_d = frm_q + FRM_W'(1);
              end
            end
          end
        end
        default: st_d = ST_FILL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FILL;
      reg_q  <= '0;
      frm_q  <= '0;
      wrd_q  <= '0;
      rreg_q <= '0;
      rwrd_q <= '0;
    end else begin
      st_q   <= st_d;
      reg_q  <= reg_d;
      frm_q  <= frm_d;
      wrd_q  <= wrd_d;
      rreg_q <= rreg_d;
      rwrd_q <= rwrd_d;
    end
  end

  assign wr_region = reg_q;
  assign cur_frame = frm_q;
  assign wr_word   = wrd_q;
  assign rd_region = rreg_q;
  assign rd_word   = rwrd_q;
endmodule

// File: rtl/fbuf_credit.sv
module fbuf_credit #(
  parameter int MAX_REGIONS     = 40,
  parameter int WORDS_PER_FRAME = 85,
  parameter int FIFO_DEPTH      = 85,
  localparam int RIDX_W = $clog2(MAX_REGIONS),
  localparam int CNT_W  = $clog2(MAX_REGIONS + 1),
  localparam int UW     = $clog2(FIFO_DEPTH + 1),
  localparam int LIMIT  = FIFO_DEPTH - WORDS_PER_FRAME
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       n_act,
  input  logic                   issue,
  input  logic [RIDX_W-1:0]      issue_region,
  input  logic [MAX_REGIONS-1:0] drained,
  output logic                   room_ok
);
  logic [MAX_REGIONS-1:0] short_room;

  for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_cnt
    logic [UW-1:0] used_q;
    logic          inc, dec;
    always_comb begin
      inc           = issue && (issue_region == RIDX_W'(g));
      dec           = drained[g];
      short_room[g] = (CNT_W'(g) < n_act) && (used_q > UW'(LIMIT));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          used_q <= '0;
      else if (inc && !dec) used_q <= used_q + UW'(1);
      else if (dec && !inc) used_q <= used_q - UW'(1);
    end
  end

  assign room_ok = ~|short_room;
endmodule

// File: rtl/fbuf_out_fifo.sv
module fbuf_out_fifo #(
  parameter int WORD_W = 192,
  parameter int DEPTH  = 85,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic              nonempty,
  output logic [WORD_W-1:0] head
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  always_comb begin
    full     = (cnt_q == CW'(DEPTH));
    nonempty = (cnt_q != '0);
    do_push  = push && !full;
    do_pop   = pop && nonempty;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign head = mem[rp_q];
endmodule

// File: rtl/frame_ring_ctrl.sv
module frame_ring_ctrl #(
  parameter int MAX_REGIONS     = 40,
  parameter int WORD_W          = 192,
  parameter int WORDS_PER_FRAME = 85,
  parameter int FRAME_BYTES     = 2048,
  parameter int REGION_FRAMES   = 18823,
  parameter int FIFO_DEPTH      = 85,
  parameter int ADDR_W          = 32,
  localparam int RIDX_W       = $clog2(MAX_REGIONS),
  localparam int CNT_W        = $clog2(MAX_REGIONS + 1),
  localparam int FRM_W        = $clog2(REGION_FRAMES),
  localparam int DEP_W        = $clog2(REGION_FRAMES + 1),
  localparam int WRD_W        = $clog2(WORDS_PER_FRAME),
  localparam int WORD_BYTES   = WORD_W / 8,
  localparam int REGION_BYTES = REGION_FRAMES * FRAME_BYTES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CNT_W-1:0]              cfg_pulses,
  input  logic [DEP_W-1:0]              cfg_depth,
  input  logic                          in_valid,
  input  logic [WORD_W-1:0]             in_data,
  output logic                          in_ready,
  output logic                          wr_valid,
  input  logic                          wr_ready,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [WORD_W-1:0]             wr_data,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output logic [ADDR_W-1:0]             rd_addr,
  output logic [RIDX_W-1:0]             rd_tag,
  input  logic                          rsp_valid,
  input  logic [RIDX_W-1:0]             rsp_tag,
  input  logic [WORD_W-1:0]             rsp_data,
  output logic [MAX_REGIONS-1:0]        out_valid,
  output logic [MAX_REGIONS*WORD_W-1:0] out_data,
  input  logic [MAX_REGIONS-1:0]        out_pop
);
  logic [CNT_W-1:0]       n_eff, n_q;
  logic [DEP_W-1:0]       d_eff, d_q;
  logic                   restart, room_ok;
  logic [RIDX_W-1:0]      wr_region, rd_region;
  logic [FRM_W-1:0]       cur_frame;
  logic [WRD_W-1:0]       wr_word, rd_word;
  logic [MAX_REGIONS-1:0] fifo_full, drained;

  always_comb begin
    if (cfg_pulses == '0)                       n_eff = CNT_W'(1);
    else if (cfg_pulses > CNT_W'(MAX_REGIONS))  n_eff = CNT_W'(MAX_REGIONS);
    else                                        n_eff = cfg_pulses;
    if (cfg_depth == '0)                        d_eff = DEP_W'(1);
    else if (cfg_depth > DEP_W'(REGION_FRAMES)) d_eff = DEP_W'(REGION_FRAMES);
    else                                        d_eff = cfg_depth;
    restart = (n_eff != n_q) || (d_eff != d_q);
    drained = out_pop & out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= CNT_W'(1);
      d_q <= DEP_W'(1);
    end else if (restart) begin
      n_q <= n_eff;
      d_q <= d_eff;
    end
  end

  fbuf_seq #(
    .MAX_REGIONS(MAX_REGIONS), .REGION_FRAMES(REGION_FRAMES), .WORDS_PER_FRAME(WORDS_PER_FRAME)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .n_act(n_q), .depth(d_q), .restart(restart),
    .in_valid(in_valid), .wr_ready(wr_ready), .rd_ready(rd_ready), .room_ok(room_ok),
    .in_ready(in_ready), .wr_valid(wr_valid), .wr_region(wr_region), .cur_frame(cur_frame),
    .wr_word(wr_word), .rd_valid(rd_valid), .rd_region(rd_region), .rd_word(rd_word)
  );

  fbuf_addr #(
    .ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .FRM_W(FRM_W), .WRD_W(WRD_W),
    .REGION_BYTES(REGION_BYTES), .FRAME_BYTES(FRAME_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_wr_addr (.region(wr_region), .frame(cur_frame), .word(wr_word), .addr(wr_addr));

  fbuf_addr #(
    .ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .FRM_W(FRM_W), .WRD_W(WRD_W),
    .REGION_BYTES(REGION_BYTES), .FRAME_BYTES(FRAME_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_rd_addr (.region(rd_region), .frame(cur_frame), .word(rd_word), .addr(rd_addr));

  fbuf_credit #(
    .MAX_REGIONS(MAX_REGIONS), .WORDS_PER_FRAME(WORDS_PER_FRAME), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_credit (
    .clk(clk), .rst_n(rst_n), .n_act(n_q), .issue(rd_valid && rd_ready),
    .issue_region(rd_region), .drained(drained), .room_ok(room_ok)
  );

  for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_out
    fbuf_out_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(rsp_valid && (rsp_tag == RIDX_W'(g))), .push_data(rsp_data),
      .pop(out_pop[g]), .full(fifo_full[g]), .nonempty(out_valid[g]),
      .head(out_data[g*WORD_W +: WORD_W])
    );
  end

  assign wr_data = in_data;
  assign rd_tag  = rd_region;
endmodule

// File: rtl/fbuf_checker.sv
module fbuf_checker #(
  parameter int MAX_REGIONS = 40,
  parameter int ADDR_W      = 32,
  localparam int RIDX_W = $clog2(MAX_REGIONS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic                   room_ok,
  input logic                   restart,
  input logic                   rsp_valid,
  input logic [RIDX_W-1:0]      rsp_tag,
  input logic [MAX_REGIONS-1:0] fifo_full
);
  AST_RD_START_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> room_ok); // R6
  AST_NO_INPUT_DURING_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !in_ready); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (restart || (rd_valid && $stable(rd_addr)))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !fifo_full[rsp_tag]); // R5
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !rd_valid); // R7
endmodule

bind frame_ring_ctrl fbuf_checker #(.MAX_REGIONS(MAX_REGIONS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_frame_ring_ctrl.sv
module tb_frame_ring_ctrl;
  localparam int MAXR = 4;
  localparam int WW   = 16;
  localparam int WPF  = 4;
  localparam int FB   = 16;
  localparam int RF   = 8;
  localparam int FD   = 6;
  localparam int AW   = 32;
  localparam int RB   = RF * FB;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cfg_pulses;
  logic [3:0] cfg_depth;
  logic in_valid;
  logic [WW-1:0] in_data;
  logic in_ready, wr_valid, rd_valid;
  logic wr_ready, rd_ready;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [WW-1:0] wr_data;
  logic [1:0] rd_tag;
  logic rsp_valid;
  logic [1:0] rsp_tag;
  logic [WW-1:0] rsp_data;
  logic [MAXR-1:0] out_valid;
  logic [MAXR*WW-1:0] out_data;
  logic [MAXR-1:0] out_pop;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  frame_ring_ctrl #(
    .MAX_REGIONS(MAXR), .WORD_W(WW), .WORDS_PER_FRAME(WPF), .FRAME_BYTES(FB),
    .REGION_FRAMES(RF), .FIFO_DEPTH(FD), .ADDR_W(AW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_pulses(cfg_pulses), .cfg_depth(cfg_depth),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_tag(rd_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_data(out_data), .out_pop(out_pop)
  );

  // memory model: writes land at once, reads answer two cycles after acceptance
  logic [WW-1:0] mem [0:511];
  logic s1_v;
  logic [AW-1:0] s1_a;
  logic [1:0] s1_t;
  always @(posedge clk) begin
    if (wr_valid && wr_ready) mem[wr_addr[8:0]] <= wr_data;
    s1_v      <= rd_valid && rd_ready && rst_n;
    s1_a      <= rd_addr;
    s1_t      <= rd_tag;
    rsp_valid <= s1_v;
    rsp_tag   <= s1_t;
    rsp_data  <= mem[s1_a[8:0]];
  end

  // request logs, sampled one nanosecond before each rising edge
  int wlog [0:255];
  int rlog [0:255];
  int tlog [0:255];
  int wcnt = 0;
  int rcnt = 0;
  always @(negedge clk) begin
    #4;
    if (wr_valid && wr_ready && wcnt < 256) begin wlog[wcnt] = int'(wr_addr); wcnt++; end
    if (rd_valid && rd_ready && rcnt < 256) begin
      rlog[rcnt] = int'(rd_addr); tlog[rcnt] = int'(rd_tag); rcnt++;
    end
  end

  function automatic int xaddr(int r, int f, int w);
    return r * RB + f * FB + w * (WW / 8);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_frame(int tag);
    for (int w = 0; w < WPF; w++) begin
      int guard = 0;
      in_valid = 1'b1;
      in_data  = {tag[7:0], w[7:0]};
      #1;
      while (!in_ready && guard < 2000) begin @(negedge clk); #1; guard++; end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic chk_wframe(int base, int r, int f, string req);
    int bad = 0;
    for (int w = 0; w < WPF; w++) if (wlog[base + w] != xaddr(r, f, w)) bad++;
    chk(bad == 0, req, "frame write address", wlog[base], xaddr(r, f, 0));
  endtask

  task automatic wait_reads(int target);
    int guard = 0;
    while (rcnt < target && guard < 500) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_rslot(int base, int n, int f, string req);
    int bad = 0;
    for (int i = 0; i < n * WPF; i++) begin
      if (rlog[base + i] != xaddr(i / WPF, f, i % WPF)) bad++;
      if (tlog[base + i] != i / WPF) bad++;
    end
    chk(bad == 0, req, "read slot order/address", rlog[base], xaddr(0, f, 0));
  endtask

  task automatic pop_frame(int r, int tag, string req);
    int bad = 0;
    int got = 0;
    for (int w = 0; w < WPF; w++) begin
      int guard = 0;
      while (!out_valid[r] && guard < 200) begin @(negedge clk); guard++; end
      if (out_data[r*WW +: WW] != {tag[7:0], w[7:0]}) begin
        bad++; got = int'(out_data[r*WW +: WW]);
      end
      out_pop[r] = 1'b1;
      @(negedge clk);
      out_pop[r] = 1'b0;
    end
    chk(bad == 0, req, $sformatf("fifo %0d data", r), got, {tag[7:0], 8'd0});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(wr_valid == 1'b0 && rd_valid == 1'b0, "R9", "request valid in reset", int'(wr_valid | rd_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == '0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(rd_valid == 1'b0 && in_ready == 1'b1, "R9", "idle handshake", int'({rd_valid, in_ready}), 1);
  endtask

  task automatic t_fill;
    int base;
    cfg_pulses = 3'd3; cfg_depth = 4'd2;
    @(negedge clk);
    base = wcnt;
    for (int k = 0; k < 6; k++) send_frame(k);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 6; k++) chk_wframe(base + k * WPF, k / 2, k % 2, "R2");
    chk(wcnt == base + 6 * WPF, "R1", "write beat count", wcnt, base + 6 * WPF);
    chk(rcnt == 0, "R2", "reads during fill", rcnt, 0);
  endtask

  task automatic t_steady;
    int base;
    int rb;
    base = wcnt; rb = rcnt;
    send_frame(6);
    wait_reads(rb + 3 * WPF);
    chk_wframe(base, 0, 0, "R3");
    chk_rslot(rb, 3, 0, "R4");
    chk(out_valid[3] == 1'b0, "R5", "inactive fifo valid", int'(out_valid[3]), 0);
    // FIFOs hold a frame each: the next frame's reads must wait
    base = wcnt; rb = rcnt;
    send_frame(7);
    repeat (20) @(negedge clk);
    chk(rcnt == rb, "R6", "reads issued without room", rcnt, rb);
    chk(in_ready == 1'b0, "R6", "in_ready while reads wait", int'(in_ready), 0);
    pop_frame(0, 6, "R5"); pop_frame(1, 2, "R5"); pop_frame(2, 4, "R5");
    wait_reads(rb + 3 * WPF);
    chk_wframe(base, 0, 1, "R1");
    chk_rslot(rb, 3, 1, "R4");
    pop_frame(0, 7, "R5"); pop_frame(1, 3, "R5"); pop_frame(2, 5, "R5");
    for (int k = 8; k <= 12; k++) begin
      base = wcnt; rb = rcnt;
      send_frame(k);
      wait_reads(rb + 3 * WPF);
      chk_wframe(base, ((k - 6) / 2) % 3, k % 2, "R3");
      chk_rslot(rb, 3, k % 2, "R4");
      for (int r = 0; r < 3; r++) begin
        int slot_tag;
        slot_tag = (r == ((k - 6) / 2) % 3) ? k : ((k - 6) / 2 < r ? 2 * r + (k % 2) : 6 + 2 * r + (k % 2));
        if ((k - 6) / 2 >= 3 && r < ((k - 6) / 2) % 3) slot_tag = 12 + 2 * r + (k % 2);
        pop_frame(r, slot_tag, "R3");
      end
    end
  endtask

  task automatic t_restart;
    int base;
    int rb;
    cfg_pulses = 3'd1; cfg_depth = 4'd1;
    @(negedge clk);
    base = wcnt; rb = rcnt;
    send_frame(20);
    repeat (15) @(negedge clk);
    chk_wframe(base, 0, 0, "R7");
    chk(rcnt == rb, "R7", "reads in first frame after restart", rcnt, rb);
    base = wcnt;
    send_frame(21);
    wait_reads(rb + WPF);
    chk_wframe(base, 0, 0, "R7");
    chk_rslot(rb, 1, 0, "R4");
    chk(out_valid[1] == 1'b0, "R5", "inactive fifo 1 valid", int'(out_valid[1]), 0);
    pop_frame(0, 21, "R5");
  endtask

  task automatic t_clamp;
    int base;
    int rb;
    cfg_pulses = 3'd7; cfg_depth = 4'd0;
    @(negedge clk);
    base = wcnt; rb = rcnt;
    for (int k = 0; k < 4; k++) send_frame(30 + k);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 4; k++) chk_wframe(base + k * WPF, k, 0, "R8");
    chk(rcnt == rb, "R8", "reads during clamped fill", rcnt, rb);
    base = wcnt;
    send_frame(34);
    wait_reads(rb + 4 * WPF);
    chk_wframe(base, 0, 0, "R8");
    chk_rslot(rb, 4, 0, "R8");
    pop_frame(0, 34, "R5"); pop_frame(1, 31, "R5"); pop_frame(2, 32, "R5"); pop_frame(3, 33, "R5");
    // pulse count 0 acts as 1
    cfg_pulses = 3'd0; cfg_depth = 4'd1;
    @(negedge clk);
    rb = rcnt;
    send_frame(40);
    base = wcnt;
    send_frame(41);
    wait_reads(rb + WPF);
    chk_wframe(base, 0, 0, "R8");
    chk(rcnt == rb + WPF, "R8", "read count for pulse count 0", rcnt, rb + WPF);
    pop_frame(0, 41, "R8");
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_pulses = 3'd1; cfg_depth = 4'd1;
    in_valid = 1'b0; in_data = '0;
    wr_ready = 1'b1; rd_ready = 1'b1;
    out_pop = '0;
    @(negedge clk);
    t_reset;
    t_fill;
    t_steady;
    t_restart;
    t_clamp;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule